// File: doc/BRIEF.md
# Neutral current mismatch detector

This block is a tamper check for a three-phase current measurement path. On each sample strobe it latches three signed phase-current samples and one signed neutral-current sample. It adds the three phase samples into a 28-bit signed sum. It then takes the magnitude of that sum, subtracts the magnitude of the neutral sample, and compares the absolute value of the result with a programmable signed threshold. In a healthy installation the neutral current equals the sum of the phase currents, so the test value stays small. A test value above the threshold points to a possible tamper event.

A mismatch sets a sticky status flag. Software clears the flag by writing a 1 to it. The flag drives an active-low interrupt through a mask bit. A one-cycle ready pulse shows when a new sum has been stored. A small register port gives read access to the sum and read/write access to the threshold, the status flag and the mask. The threshold is signed. A threshold of zero or below means the mismatch event fires on every sample, and zero is the value after reset.

The work is paced by a three-state sequencer:
- `S_IDLE` waits for a strobe and latches the samples (transition *capture*).
- `S_ADD` forms the sum (transition *add_done*).
- `S_CMP` evaluates the mismatch test and raises the ready pulse (transition *cmp_done*, back to `S_IDLE`).

Top module: `nmis_detector`

## Requirements
- R1: After reset, all four register words read 0, `irq_n` is 1 and `sum_rdy` is 0. The stored threshold is 0.
- R2: The sum register holds ph_a+ph_b+ph_c as a 28-bit two's-complement value. Reading address 0 returns it in bits 27:0, with bit 27 as the sign and bits 31:28 zero.
- R3: The strobe is sampled at clock edge E0. The new sum is stored at edge E1. The flag update and a one-cycle `sum_rdy` pulse both take effect at edge E2, and `sum_rdy` is low again after E3.
- R4: With a stored threshold of 0 or any negative value, every processed sample sets the flag, even when the neutral sample matches the sum exactly.
- R5: With a positive threshold T, a processed sample sets the flag only if ||sum|-|ph_n|| > T. A test value equal to T leaves the flag unchanged. The signs of the sum and of the neutral sample do not matter.
- R6: The flag is bit 20 of address 2. Once set, it stays set. It is cleared only by a write to address 2 with bit 20 = 1. A write with bit 20 = 0 has no effect.
- R7: If a mismatch set and a clearing write fall on the same clock edge, the flag ends up set.
- R8: `irq_n` is 0 exactly while the flag is 1 and the mask bit is 1. The mask bit is bit 20 of address 3, and it is read/write.
- R9: A write to address 1 stores bits 23:0 of the write data as the threshold. Reading address 1 returns that value sign-extended to 28 bits, with bits 31:28 zero. Writing 0x5A7540 gives the full-scale level.
- R10: A strobe that arrives while the sequencer is in `S_ADD` or `S_CMP` is ignored. The sum and the flag reflect only the sample that was accepted.
- R11: Writes to address 0 have no effect on the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| ph_a | input | 24 | Phase A current sample, signed |
| ph_b | input | 24 | Phase B current sample, signed |
| ph_c | input | 24 | Phase C current sample, signed |
| ph_n | input | 24 | Neutral current sample, signed |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word address (0 sum, 1 threshold, 2 status, 3 mask) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| sum_rdy | output | 1 | One-cycle pulse when a new sum and flag result are in place |
| irq_n | output | 1 | Active-low mismatch interrupt |

## Verification
Counting the strobe edge as E0, the sum becomes readable after E1, and the flag and the ready pulse become visible after E2. The interrupt follows the flag and the mask in the same cycle, because it is combinational from registers. Register writes take effect at the single edge that follows the write cycle, and reads are combinational. The bench therefore drives inputs on falling edges and samples just after a falling edge, at the cycle where the count of registers predicts the change. The timing and set-wins cases place a strobe or a clear write on a chosen edge and check the values on both sides of it.

// File: rtl/nmis_pkg.sv
package nmis_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADD  = 2'd1,
        S_CMP  = 2'd2
    } nmis_state_e;

    localparam logic [1:0] ADDR_SUM  = 2'd0;
    localparam logic [1:0] ADDR_THR  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_MASK = 2'd3;

endpackage

// File: rtl/nmis_ctrl.sv
module nmis_ctrl
    import nmis_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_vld,
    output nmis_state_e state,
    output logic        cap_en,
    output logic        sum_en,
    output logic        cmp_en,
    output logic        rdy_q
);

    nmis_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (smp_vld) state_d = S_ADD;   // capture
            S_ADD:   state_d = S_CMP;                // add_done
            S_CMP:   state_d = S_IDLE;               // cmp_done
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cap_en = 1'b0;
        sum_en = 1'b0;
        cmp_en = 1'b0;
        unique case (state_q)
            S_IDLE:  cap_en = smp_vld;
            S_ADD:   sum_en = 1'b1;
            S_CMP:   cmp_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= cmp_en;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/nmis_datapath.sv
module nmis_datapath #(
    parameter int SMP_W = 24,
    parameter int SUM_W = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic                    sum_en,
    input  logic signed [SMP_W-1:0] ph_a,
    input  logic signed [SMP_W-1:0] ph_b,
    input  logic signed [SMP_W-1:0] ph_c,
    input  logic signed [SMP_W-1:0] ph_n,
    input  logic signed [SMP_W-1:0] thr,
    output logic signed [SUM_W-1:0] sum_q,
    output logic                    mismatch
);

    localparam int EXT_W = SUM_W - SMP_W;
    localparam int DIF_W = SUM_W + 2;
    localparam int NPH   = 3;

    logic signed [SMP_W-1:0] smp_q [NPH];
    logic signed [SMP_W-1:0] smp_in [NPH];
    logic signed [SMP_W-1:0] neu_q;
    logic signed [SUM_W-1:0] ext   [NPH];
    logic signed [SUM_W-1:0] sum_d;

    assign smp_in[0] = ph_a;
    assign smp_in[1] = ph_b;
    assign smp_in[2] = ph_c;

    // sample capture, one lane per phase
    for (genvar g = 0; g < NPH; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[g] <= '0;
            end else if (cap_en) begin
                smp_q[g] <= smp_in[g];
            end
        end
        assign ext[g] = {{EXT_W{smp_q[g][SMP_W-1]}}, smp_q[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neu_q <= '0;
        end else if (cap_en) begin
            neu_q <= ph_n;
        end
    end

    assign sum_d = ext[0] + ext[1] + ext[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (sum_en) begin
            sum_q <= sum_d;
        end
    end

    // magnitude compare at a width with headroom
    logic signed [DIF_W-1:0] sum_x, neu_x, thr_x;
    logic signed [DIF_W-1:0] mag_s, mag_n, dif, adif;

    assign sum_x = {{(DIF_W-SUM_W){sum_q[SUM_W-1]}}, sum_q};
    assign neu_x = {{(DIF_W-SMP_W){neu_q[SMP_W-1]}}, neu_q};
    assign thr_x = {{(DIF_W-SMP_W){thr[SMP_W-1]}}, thr};

    assign mag_s = sum_x[DIF_W-1] ? -sum_x : sum_x;
    assign mag_n = neu_x[DIF_W-1] ? -neu_x : neu_x;
    assign dif   = mag_s - mag_n;
    assign adif  = dif[DIF_W-1] ? -dif : dif;

    assign mismatch = (thr_x <= 0) || (adif > thr_x);

endmodule

// File: rtl/nmis_regs.sv
module nmis_regs
    import nmis_pkg::*;
#(
    parameter int SMP_W    = 24,
    parameter int SUM_W    = 28,
    parameter int BUS_W    = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [BUS_W-1:0]        reg_wdata,
    input  logic                    set_hit,
    input  logic signed [SUM_W-1:0] sum_q,
    output logic [BUS_W-1:0]        reg_rdata,
    output logic signed [SMP_W-1:0] thr_q,
    output logic                    flag_q,
    output logic                    mask_q,
    output logic                    irq_n
);

    localparam int PAD_W = BUS_W - SUM_W;
    localparam int EXT_W = SUM_W - SMP_W;

    logic wr_thr, wr_mask, clr_flag;
    wire  unused_wbits = ^reg_wdata;

    assign wr_thr   = reg_wr && (reg_addr == ADDR_THR);
    assign wr_mask  = reg_wr && (reg_addr == ADDR_MASK);
    assign clr_flag = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (wr_thr) begin
            thr_q <= reg_wdata[SMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_mask) begin
            mask_q <= reg_wdata[FLAG_BIT];
        end
    end

    // set has priority over write-1-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_hit) begin
            flag_q <= 1'b1;
        end else if (clr_flag) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_SUM:  reg_rdata = {{PAD_W{1'b0}}, sum_q};
            ADDR_THR:  reg_rdata = {{PAD_W{1'b0}}, {EXT_W{thr_q[SMP_W-1]}}, thr_q};
            ADDR_STAT: reg_rdata[FLAG_BIT] = flag_q;
            ADDR_MASK: reg_rdata[FLAG_BIT] = mask_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_n = ~(flag_q & mask_q);

endmodule

// File: rtl/nmis_detector.sv
module nmis_detector
    import nmis_pkg::*;
#(
    parameter int SMP_W    = 24,
    parameter int SUM_W    = 28,
    parameter int BUS_W    = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] ph_a,
    input  logic signed [SMP_W-1:0] ph_b,
    input  logic signed [SMP_W-1:0] ph_c,
    input  logic signed [SMP_W-1:0] ph_n,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [BUS_W-1:0]        reg_wdata,
    output logic [BUS_W-1:0]        reg_rdata,
    output logic                    sum_rdy,
    output logic                    irq_n
);

    nmis_state_e             state;
    logic                    cap_en, sum_en, cmp_en;
    logic                    mismatch;
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SMP_W-1:0] thr_q;
    logic                    flag_q, mask_q;

    nmis_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .state   (state),
        .cap_en  (cap_en),
        .sum_en  (sum_en),
        .cmp_en  (cmp_en),
        .rdy_q   (sum_rdy)
    );

    nmis_datapath #(
        .SMP_W (SMP_W),
        .SUM_W (SUM_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .sum_en   (sum_en),
        .ph_a     (ph_a),
        .ph_b     (ph_b),
        .ph_c     (ph_c),
        .ph_n     (ph_n),
        .thr      (thr_q),
        .sum_q    (sum_q),
        .mismatch (mismatch)
    );

    nmis_regs #(
        .SMP_W    (SMP_W),
        .SUM_W    (SUM_W),
        .BUS_W    (BUS_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .set_hit   (cmp_en & mismatch),
        .sum_q     (sum_q),
        .reg_rdata (reg_rdata),
        .thr_q     (thr_q),
        .flag_q    (flag_q),
        .mask_q    (mask_q),
        .irq_n     (irq_n)
    );

endmodule

// File: rtl/nmis_detector_chk.sv
module nmis_detector_chk
    import nmis_pkg::*;
#(
    parameter int SMP_W    = 24,
    parameter int BUS_W    = 32,
    parameter int FLAG_BIT = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input nmis_state_e             state,
    input logic                    flag_q,
    input logic signed [SMP_W-1:0] thr_q,
    input logic                    sum_rdy,
    input logic                    irq_n,
    input logic                    reg_wr,
    input logic [1:0]              reg_addr,
    input logic [BUS_W-1:0]        reg_wdata
);

    logic clr_req;
    assign clr_req = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[FLAG_BIT];

    a_r3_add_then_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_ADD |=> state == S_CMP);

    a_r3_rdy_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        sum_rdy |-> $past(state) == S_CMP);

    a_r4_nonpos_thr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMP && thr_q <= 0) |=> flag_q);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

    a_r5_set_only_from_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(state) == S_CMP);

    a_r8_no_irq_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |-> irq_n);

endmodule

bind nmis_detector nmis_detector_chk #(
    .SMP_W    (SMP_W),
    .BUS_W    (BUS_W),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .flag_q    (flag_q),
    .thr_q     (thr_q),
    .sum_rdy   (sum_rdy),
    .irq_n     (irq_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/nmis_detector_tb.sv
module nmis_detector_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [23:0] ph_a = '0, ph_b = '0, ph_c = '0, ph_n = '0;
    logic               reg_wr = 1'b0;
    logic [1:0]         reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               sum_rdy, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nmis_detector dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .ph_n(ph_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sum_rdy(sum_rdy), .irq_n(irq_n)
    );

    typedef struct packed {
        logic signed [23:0] a, b, c, n, thr;
        logic               flag;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{24'sd100,   24'sd200,   24'sd300,   24'sd600,    24'sd10,     1'b0},
        '{24'sd100,   24'sd200,   24'sd300,   24'sd500,    24'sd100,    1'b0},
        '{24'sd100,   24'sd200,   24'sd300,   24'sd499,    24'sd100,    1'b1},
        '{-24'sd1000, -24'sd2000, -24'sd3000, 24'sd6000,   24'sd5,      1'b0},
        '{-24'sd1000, -24'sd2000, -24'sd3000, -24'sd5000,  24'sd999,    1'b1},
        '{24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF,  24'h5A7540,  1'b1},
        '{24'h800000, 24'h800000, 24'h800000, 24'h800000,  24'h7FFFFF,  1'b1},
        '{24'sd5,     -24'sd5,    24'sd0,     24'sd0,      24'sd1,      1'b0},
        '{24'sd0,     24'sd0,     24'sd0,     24'sd50,     24'h7FFFFF,  1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sum(logic signed [23:0] a, b, c);
        int s;
        s = int'(a) + int'(b) + int'(c);
        return {4'b0, s[27:0]};
    endfunction

    task automatic wr(logic [1:0] addr, logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr = addr;
        #1 data = reg_rdata;
    endtask

    // strobe accepted at E0; returns just after E2
    task automatic sample(logic signed [23:0] a, b, c, n);
        @(negedge clk);
        ph_a = a; ph_b = b; ph_c = c; ph_n = n; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [31:0] FLAGW = 32'h0010_0000;

    initial begin
        logic [31:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            reg_addr = 2'(i);
            #1 check("R1 reset read", reg_rdata, 32'h0);
        end
        check("R1 reset irq_n", {31'b0, irq_n}, 32'h1);
        check("R1 reset sum_rdy", {31'b0, sum_rdy}, 32'h0);
        rst_n = 1'b1;

        // vector table: R2, R5
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, {8'h00, VECS[i].thr});
            wr(2'd2, FLAGW);
            sample(VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].n);
            check("R3 ready pulse", {31'b0, sum_rdy}, 32'h1);
            rd(2'd0, v);
            check("R2 sum readback", v, exp_sum(VECS[i].a, VECS[i].b, VECS[i].c));
            rd(2'd2, v);
            check("R5 flag vs threshold", v, VECS[i].flag ? FLAGW : 32'h0);
        end

        // R9 threshold readback
        wr(2'd1, 32'h0080_0000);
        rd(2'd1, v); check("R9 negative thr readback", v, 32'h0F80_0000);
        wr(2'd1, 32'hFF12_3456);
        rd(2'd1, v); check("R9 upper bits dropped", v, 32'h0012_3456);
        wr(2'd1, 32'h005A_7540);
        rd(2'd1, v); check("R9 full scale readback", v, 32'h005A_7540);

        // R4 zero and negative threshold on exact match
        wr(2'd1, 32'h0);
        wr(2'd2, FLAGW);
        sample(24'sd100, 24'sd200, 24'sd300, 24'sd600);
        rd(2'd2, v); check("R4 zero threshold fires", v, FLAGW);
        wr(2'd1, 32'h00FF_FFFB);
        wr(2'd2, FLAGW);
        sample(24'sd100, 24'sd200, 24'sd300, 24'sd600);
        rd(2'd2, v); check("R4 negative threshold fires", v, FLAGW);

        // R6 write of 0 keeps flag, write of 1 clears
        wr(2'd2, 32'hFFEF_FFFF);
        rd(2'd2, v); check("R6 write 0 no clear", v, FLAGW);
        wr(2'd2, FLAGW);
        rd(2'd2, v); check("R6 write 1 clears", v, 32'h0);

        // R8 interrupt through mask (threshold still negative)
        wr(2'd3, FLAGW);
        rd(2'd3, v); check("R8 mask readback", v, FLAGW);
        #1 check("R8 irq high with flag clear", {31'b0, irq_n}, 32'h1);
        sample(24'sd1, 24'sd1, 24'sd1, 24'sd3);
        check("R8 irq low", {31'b0, irq_n}, 32'h0);
        wr(2'd3, 32'h0);
        #1 check("R8 irq released by mask", {31'b0, irq_n}, 32'h1);
        wr(2'd3, FLAGW);
        #1 check("R8 irq low again", {31'b0, irq_n}, 32'h0);
        wr(2'd2, FLAGW);
        #1 check("R8 irq released by clear", {31'b0, irq_n}, 32'h1);
        wr(2'd3, 32'h0);

        // R3 cycle timing, thr positive and a clear mismatch
        wr(2'd1, 32'h0000_0064);
        wr(2'd2, FLAGW);
        @(negedge clk);
        ph_a = 24'sd1000; ph_b = 24'sd0; ph_c = 24'sd0; ph_n = 24'sd0; smp_vld = 1'b1;
        @(negedge clk); smp_vld = 1'b0; reg_addr = 2'd2;     // after E0
        #1 check("R3 no ready after E0", {31'b0, sum_rdy}, 32'h0);
        @(negedge clk); reg_addr = 2'd0;                     // after E1
        #1 check("R3 sum after E1", reg_rdata, 32'h0000_03E8);
        reg_addr = 2'd2;
        #1 check("R3 flag not yet after E1", reg_rdata, 32'h0);
        check("R3 no ready after E1", {31'b0, sum_rdy}, 32'h0);
        @(negedge clk);                                      // after E2
        #1 check("R3 flag after E2", reg_rdata, FLAGW);
        check("R3 ready after E2", {31'b0, sum_rdy}, 32'h1);
        @(negedge clk);
        #1 check("R3 ready gone after E3", {31'b0, sum_rdy}, 32'h0);

        // R7 set wins against clear on the same edge (flag already 1)
        @(negedge clk);
        smp_vld = 1'b1;
        @(negedge clk); smp_vld = 1'b0;
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = FLAGW;
        @(negedge clk); reg_wr = 1'b0;
        rd(2'd2, v); check("R7 set wins", v, FLAGW);

        // R10 strobe during busy ignored; R11 write to sum ignored
        wr(2'd2, FLAGW);
        @(negedge clk);
        ph_a = 24'sd10; ph_b = 24'sd20; ph_c = 24'sd30; ph_n = 24'sd60; smp_vld = 1'b1;
        @(negedge clk);                                      // E0 accepted
        ph_a = 24'sd4000; ph_b = 24'sd0; ph_c = 24'sd0; ph_n = 24'sd0;
        @(negedge clk);                                      // E1 in S_ADD, ignored
        @(negedge clk); smp_vld = 1'b0;                      // E2 in S_CMP, ignored
        @(negedge clk);
        rd(2'd0, v); check("R10 sum from accepted sample", v, 32'h0000_003C);
        rd(2'd2, v); check("R10 flag from accepted sample", v, 32'h0);
        wr(2'd0, 32'h0ABC_DEF0);
        rd(2'd0, v); check("R11 sum write ignored", v, 32'h0000_003C);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule